// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Model

This block is a synthesizable, cycle-level model of a synchronous burst static RAM built around a small parameterized array. Address, write data and all commands are sampled on the rising clock edge. Two address strobes open an access. The processor-side strobe always starts a read. The controller-side strobe starts a write when one is requested and a read otherwise. Once a burst is open, the advance input steps a two-bit address counter through either a linear or an interleaved order.

A mode input chooses the read latency. In flow-through mode, data is valid right after the edge that captured the read. In pipelined mode it is valid one edge later. In both modes a deselect shuts the bus off one stage earlier than a read would appear, which is single-cycle deselect. Writes take a global or a per-byte mask. The output enable acts without the clock. A sleep input freezes the command path while keeping the array contents, and a wake-up count of cycles must pass before commands are accepted again.

The data bus is modelled as a read-data vector plus a drive-enable flag. The enclosing logic turns these into a tri-state pad.

Top module: `sync_burst_sram`

## Requirements
- R1: A strobe cycle selects the device only when ce1_n=0, ce2=1 and ce3_n=0. Any other combination on a strobe cycle is a deselect: nothing is written, no data is driven after that edge, and any open burst ends.
- R2: On edges with both strobes high, the enable inputs are ignored, and an open burst keeps reading or writing.
- R3: A selected edge with strb_proc_n=0 always performs a read, whatever the write inputs are, and leaves the array unchanged.
- R4: A selected edge with strb_proc_n=1 and strb_ctrl_n=0 writes when R5 yields a non-empty mask and reads otherwise. Burst continuation edges follow the same rule.
- R5: With gwr_n=0 every byte is written. Otherwise, with bwr_n=0, bit i of ben_n low writes byte i (wdata bits 8i+7..8i), in any combination. Every other combination is a read.
- R6: A burst edge with adv_n=0 steps a two-bit count. The accessed low address bits are start+count mod 4 when seq_lin_n=0, and start XOR count when seq_lin_n=1. The count wraps back to the start address on the fifth access. With adv_n=1 the address is held.
- R7: With flow_n=0, data read at an edge is on rdata with rdata_oe=1 right after that edge.
- R8: With flow_n=1, data read at an edge appears right after the following edge.
- R9: With flow_n=1, when a deselect is captured at edge k after a read at edge k-1, the read data is still driven after edge k, and rdata_oe is 0 after edge k+1.
- R10: With flow_n=0, rdata_oe is 0 after every write edge. Reads drive all bytes regardless of ben_n.
- R11: oe_n=1 forces rdata_oe=0 at once, without waiting for a clock edge. A read made while oe_n=1 still advances the burst address.
- R12: An edge with sleep=1 ignores all commands and ends any open burst, and rdata_oe is 0 after it. Array contents are kept.
- R13: After sleep returns low, the first WAKE_CYC edges are still ignored. The next edge accepts commands.
- R14: After reset, rdata_oe=0 and no burst is open, so an advance without a strobe does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Access start address |
| wdata | input | NBYTES*BYTE_W | Write data |
| ce1_n | input | 1 | Primary enable, active low |
| ce2 | input | 1 | Second enable, active high |
| ce3_n | input | 1 | Third enable, active low |
| strb_proc_n | input | 1 | Processor-side strobe, active low |
| strb_ctrl_n | input | 1 | Controller-side strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Write all bytes, active low |
| bwr_n | input | 1 | Byte-masked write, active low |
| ben_n | input | NBYTES | Per-byte write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_n | input | 1 | 0 flow-through, 1 pipelined |
| seq_lin_n | input | 1 | 0 linear order, 1 interleaved order |
| sleep | input | 1 | Low-power hold, active high |
| rdata | output | NBYTES*BYTE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Bus drive enable |

## Verification
Two functions can share a cycle. In pipelined mode, the output of the previous read and a freshly captured deselect meet at the same edge. The bench issues a read and then a deselect on the very next edge. It expects the old word still driven after that edge and the bus released one edge later. The sleep path is provoked in the same way. Sleep is raised while a burst is open and a write strobe is presented, and the bench then expects the bus dark and the target word unchanged. Reads attempted during the wake-up window must stay undriven until exactly WAKE_CYC edges have passed.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} sbs_op_e;

  // low address bits of a burst beat: linear adds, interleaved xors
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       linear);
    return linear ? 2'(start + step) : (start ^ step);
  endfunction
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import sbs_pkg::*;
#(
  parameter int NBYTES = 2
) (
  input  logic              dormant,
  input  logic              active,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_n,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [NBYTES-1:0] ben_n,
  output sbs_op_e           op,
  output logic              start,
  output logic              advance,
  output logic              go_idle,
  output logic [NBYTES-1:0] wmask
);
  logic sel;
  logic wr_req;
  logic any_strb;

  always_comb begin
    sel      = !ce1_n && ce2 && !ce3_n;
    any_strb = !strb_proc_n || !strb_ctrl_n;
    if (!gwr_n)      wmask = '1;
    else if (!bwr_n) wmask = ~ben_n;
    else             wmask = '0;
    wr_req  = |wmask;
    op      = OP_NONE;
    start   = 1'b0;
    advance = 1'b0;
    go_idle = 1'b0;
    if (dormant) begin
      go_idle = 1'b1;
    end else if (any_strb) begin
      if (sel) begin
        start = 1'b1;
        op    = (!strb_proc_n || !wr_req) ? OP_READ : OP_WRITE;
      end else begin
        go_idle = 1'b1;
      end
    end else if (active) begin
      op      = wr_req ? OP_WRITE : OP_READ;
      advance = !adv_n;
    end
  end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              advance,
  input  logic              go_idle,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_use,
  output logic              active
);
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic [1:0]        step;
  logic [ADDR_W-1:0] base_sel;

  always_comb begin
    step     = start ? 2'd0 : (advance ? 2'(cnt + 2'd1) : cnt);
    base_sel = start ? addr_in : base;
    addr_use = {base_sel[ADDR_W-1:2], burst_lo(base_sel[1:0], step, linear)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      base   <= addr_in;
      cnt    <= '0;
      active <= 1'b1;
    end else if (go_idle) begin
      active <= 1'b0;
    end else if (advance) begin
      cnt <= 2'(cnt + 2'd1);
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [NBYTES-1:0]        wmask,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic                     re,
  output logic [NBYTES*BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (we && wmask[g]) lane_mem[addr] <= wdata[g*BYTE_W +: BYTE_W];
      if (re) lane_q <= lane_mem[addr];
    end
    assign rdata[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_fire,
  input  logic          flush,
  input  logic          flow_n,
  input  logic          oe_n,
  input  logic [DW-1:0] arr_q,
  output logic [DW-1:0] out_data,
  output logic          out_en
);
  logic          ft_v;
  logic          pl_v;
  logic [DW-1:0] pl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ft_v <= 1'b0;
      pl_v <= 1'b0;
      pl_q <= '0;
    end else begin
      ft_v <= rd_fire;
      pl_v <= ft_v && !flush;
      pl_q <= arr_q;
    end
  end

  always_comb begin
    out_en   = !oe_n && (flow_n ? pl_v : ft_v);
    out_data = out_en ? (flow_n ? pl_q : arr_q) : '0;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NBYTES   = 2,
  parameter int BYTE_W   = 8,
  parameter int WAKE_CYC = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     strb_proc_n,
  input  logic                     strb_ctrl_n,
  input  logic                     adv_n,
  input  logic                     gwr_n,
  input  logic                     bwr_n,
  input  logic [NBYTES-1:0]        ben_n,
  input  logic                     oe_n,
  input  logic                     flow_n,
  input  logic                     seq_lin_n,
  input  logic                     sleep,
  output logic [NBYTES*BYTE_W-1:0] rdata,
  output logic                     rdata_oe
);
  localparam int DW   = NBYTES * BYTE_W;
  localparam int WK_W = $clog2(WAKE_CYC + 1);

  logic [WK_W-1:0]   wake_cnt;
  logic              dormant;
  logic              active;
  logic              start;
  logic              advance;
  logic              go_idle;
  logic [NBYTES-1:0] wmask;
  sbs_op_e           op;
  logic [ADDR_W-1:0] addr_use;
  logic [DW-1:0]     arr_q;

  assign dormant = sleep || (wake_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)                  wake_cnt <= '0;
    else if (sleep)           wake_cnt <= WK_W'(WAKE_CYC);
    else if (wake_cnt != '0)  wake_cnt <= wake_cnt - 1'b1;
  end

  sbs_cmd_decode #(.NBYTES(NBYTES)) u_dec (
    .dormant(dormant), .active(active),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv_n(adv_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .ben_n(ben_n),
    .op(op), .start(start), .advance(advance), .go_idle(go_idle),
    .wmask(wmask)
  );

  sbs_burst_addr #(.ADDR_W(ADDR_W)) u_adr (
    .clk(clk), .rst(rst), .start(start), .advance(advance),
    .go_idle(go_idle), .linear(!seq_lin_n), .addr_in(addr),
    .addr_use(addr_use), .active(active)
  );

  sbs_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .we(op == OP_WRITE), .wmask(wmask), .addr(addr_use),
    .wdata(wdata), .re(op == OP_READ), .rdata(arr_q)
  );

  sbs_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .rd_fire(op == OP_READ), .flush(dormant),
    .flow_n(flow_n), .oe_n(oe_n), .arr_q(arr_q),
    .out_data(rdata), .out_en(rdata_oe)
  );
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk (
  input logic clk,
  input logic rst,
  input logic flow_n,
  input logic oe_n,
  input logic sleep,
  input logic dormant,
  input logic strb_proc_n,
  input logic strb_ctrl_n,
  input logic ce1_n,
  input logic ce2,
  input logic ce3_n,
  input logic gwr_n,
  input logic rdata_oe
);
  logic sel;
  assign sel = !ce1_n && ce2 && !ce3_n;

  // R12
  sleep_dark_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !rdata_oe);

  // R10
  write_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (!flow_n && !dormant && strb_proc_n && !strb_ctrl_n && sel && !gwr_n)
    |=> (flow_n || !rdata_oe));

  // R3
  proc_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!flow_n && !dormant && !strb_proc_n && sel)
    |=> (flow_n || oe_n || rdata_oe));

  // R11
  oe_block_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rdata_oe);

  // R9
  scd_off_chk: assert property (@(posedge clk) disable iff (rst)
    (flow_n && !dormant && (!strb_proc_n || !strb_ctrl_n) && !sel)
    |=> ##1 (!flow_n || !rdata_oe));

  // R13
  wake_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && $past(sleep)) |=> !rdata_oe);
endmodule

bind sync_burst_sram sbs_chk u_chk (
  .clk(clk), .rst(rst), .flow_n(flow_n), .oe_n(oe_n), .sleep(sleep),
  .dormant(dormant), .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gwr_n(gwr_n),
  .rdata_oe(rdata_oe)
);

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 16;
  localparam int WK = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
  logic gwr_n = 1'b1, bwr_n = 1'b1;
  logic [NB-1:0] ben_n = '1;
  logic oe_n = 1'b0, flow_n = 1'b0, seq_lin_n = 1'b1, sleep = 1'b0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] mref [0:(1<<AW)-1];

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(8), .WAKE_CYC(WK)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .ce1_n(ce1_n),
    .ce2(ce2), .ce3_n(ce3_n), .strb_proc_n(strb_proc_n),
    .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n),
    .ben_n(ben_n), .oe_n(oe_n), .flow_n(flow_n), .seq_lin_n(seq_lin_n),
    .sleep(sleep), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return 16'(a * 259) ^ 16'hc35a;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_in();
    strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
    gwr_n = 1'b1; bwr_n = 1'b1; ben_n = '1;
  endtask

  task automatic wr_single(input int a, input logic [DW-1:0] d);
    strb_ctrl_n = 1'b0; gwr_n = 1'b0; addr = AW'(a); wdata = d;
    tick();
    check("R10 write edge undriven", {31'd0, rdata_oe}, 32'd0);
    mref[a] = d;
    idle_in();
  endtask

  task automatic rd_ft(input int a, input string tag);
    strb_proc_n = 1'b0; addr = AW'(a);
    tick();
    check(tag, {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, mref[a]});
    idle_in();
  endtask

  task automatic deselect();
    strb_proc_n = 1'b0; ce1_n = 1'b1;
    tick();
    ce1_n = 1'b0; idle_in();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R14 idle after reset", {31'd0, rdata_oe}, 32'd0);
    adv_n = 1'b0;
    tick();
    check("R14 advance without burst", {31'd0, rdata_oe}, 32'd0);
    idle_in();

    // fill, then flow-through read sweep
    for (int a = 0; a < (1 << AW); a++) wr_single(a, pat(a));
    for (int a = 0; a < (1 << AW); a++) rd_ft(a, "R7 flow-through read");

    // pipelined sweep ending with a single-cycle deselect
    flow_n = 1'b1;
    for (int a = 0; a <= (1 << AW); a++) begin
      if (a < (1 << AW)) begin
        strb_proc_n = 1'b0; addr = AW'(a);
      end else begin
        strb_proc_n = 1'b0; ce1_n = 1'b1;
      end
      tick();
      if (a > 0)
        check(a < (1 << AW) ? "R8 pipelined read" : "R9 data kept at deselect edge",
              {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, mref[a-1]});
    end
    ce1_n = 1'b0; idle_in();
    tick();
    check("R9 released one edge after deselect", {31'd0, rdata_oe}, 32'd0);
    flow_n = 1'b0;

    // burst orders and wrap, controller strobe without write = read (R4)
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        int b;
        seq_lin_n = (ord == 0);
        b = 20 | s;
        strb_ctrl_n = 1'b0; addr = AW'(b);
        tick();
        check("R4 ctrl strobe read", {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, mref[b]});
        strb_ctrl_n = 1'b1;
        for (int i = 1; i <= 4; i++) begin
          int lo;
          adv_n = 1'b0;
          tick();
          lo = (ord == 1) ? ((s + i) & 3) : (s ^ (i & 3));
          check("R6 burst beat", {15'd0, rdata_oe, rdata},
                {15'd0, 1'b1, mref[(b & ~3) | lo]});
        end
        adv_n = 1'b1;
        tick();
        check("R6 suspend holds", {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, mref[b]});
        idle_in();
      end
    end
    seq_lin_n = 1'b1;

    // byte masks
    for (int m = 0; m < 4; m++) begin
      logic [DW-1:0] d;
      d = 16'ha0a0 + 16'(m * 16'h0111);
      strb_ctrl_n = 1'b0; bwr_n = 1'b0; ben_n = ~NB'(m); addr = 6'd40; wdata = d;
      tick();
      if (m == 0) begin
        check("R10 byte-read drives all bytes", {15'd0, rdata_oe, rdata},
              {15'd0, 1'b1, mref[40]});
      end else begin
        check("R5 masked write undriven", {31'd0, rdata_oe}, 32'd0);
        if (m[0]) mref[40][7:0]  = d[7:0];
        if (m[1]) mref[40][15:8] = d[15:8];
      end
      idle_in();
      rd_ft(40, "R5 byte mask result");
    end
    strb_ctrl_n = 1'b0; gwr_n = 1'b0; bwr_n = 1'b0; ben_n = '1;
    addr = 6'd41; wdata = 16'hbeef;
    tick();
    mref[41] = 16'hbeef;
    idle_in();
    rd_ft(41, "R5 global write priority");

    // processor strobe ignores write inputs
    strb_proc_n = 1'b0; gwr_n = 1'b0; addr = 6'd42; wdata = 16'h1234;
    tick();
    check("R3 proc strobe reads", {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, mref[42]});
    idle_in();
    rd_ft(42, "R3 array unchanged");

    // enable decode
    for (int k = 0; k < 3; k++) begin
      ce1_n = (k == 0); ce2 = (k != 1); ce3_n = (k == 2);
      strb_ctrl_n = 1'b0; gwr_n = 1'b0; addr = 6'd43; wdata = 16'hdead;
      tick();
      check("R1 deselect undriven", {31'd0, rdata_oe}, 32'd0);
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; idle_in();
      rd_ft(43, "R1 deselect writes nothing");
    end

    // enables ignored while continuing
    strb_ctrl_n = 1'b0; addr = 6'd44;
    tick();
    strb_ctrl_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; ce1_n = 1'b1; adv_n = 1'b0;
    tick();
    check("R2 continuation ignores enables", {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, mref[45]});
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; idle_in();

    // dummy reads and asynchronous output enable
    strb_proc_n = 1'b0; addr = 6'd48; oe_n = 1'b1;
    tick();
    check("R11 oe_n high blocks drive", {31'd0, rdata_oe}, 32'd0);
    strb_proc_n = 1'b1; adv_n = 1'b0;
    tick();
    check("R11 dummy read undriven", {31'd0, rdata_oe}, 32'd0);
    oe_n = 1'b0;
    tick();
    check("R11 dummy reads advanced", {15'd0, rdata_oe, rdata}, {15'd0, 1'b1, mref[50]});
    oe_n = 1'b1;
    #0.5;
    check("R11 async disable", {31'd0, rdata_oe}, 32'd0);
    oe_n = 1'b0;
    #0.5;
    check("R11 async re-enable", {31'd0, rdata_oe}, 32'd1);
    idle_in();

    // sleep and wake-up
    strb_ctrl_n = 1'b0; addr = 6'd52;
    tick();
    strb_ctrl_n = 1'b1; adv_n = 1'b0; sleep = 1'b1;
    tick();
    check("R12 sleep darkens bus", {31'd0, rdata_oe}, 32'd0);
    adv_n = 1'b1; strb_ctrl_n = 1'b0; gwr_n = 1'b0; addr = 6'd53; wdata = 16'h7777;
    tick();
    check("R12 strobe ignored in sleep", {31'd0, rdata_oe}, 32'd0);
    idle_in(); sleep = 1'b0;
    for (int j = 0; j <= WK; j++) begin
      strb_proc_n = 1'b0; addr = 6'd53;
      tick();
      if (j < WK)
        check("R13 wake window ignored", {31'd0, rdata_oe}, 32'd0);
      else
        check("R13 R12 accepted after wake, data kept", {15'd0, rdata_oe, rdata},
              {15'd0, 1'b1, mref[53]});
    end
    idle_in();
    deselect();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule